// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces one column address per beat of a memory burst. A controller pulses a start strobe together with the first column, a three-bit length code and an ordering bit. From the next cycle on, the block presents the column of the current beat, a valid flag and a flag that marks the final beat. It advances one beat per clock until the burst is complete.

Bursts of 1, 2, 4 and 8 beats wrap inside the aligned group of columns that holds the first column. They step either in counting order or in XOR order. A full-row burst counts through every column of the row, wrapping past the top. It continues until a stop input ends it. A new start replaces whatever burst is running, on any cycle. A length code that cannot be used gives a one-beat burst and sets a sticky error flag.

Top module: `bcg_burst_col`

## Requirements
- R1: After reset `valid_o`, `last_o` and `err_o` are 0.
- R2: When `start_i` is high at a clock edge, `valid_o` is 1 after that edge and `col_o` equals `start_col_i`; this holds even if a burst is running, which is then abandoned.
- R3: With `interleave_i`=0 and a wrapped length BL, beat k has the same upper bits as the start column, and its low log2(BL) bits equal (start + k) mod BL.
- R4: With `interleave_i`=1 and a wrapped length BL, beat k equals the start column XOR k, with k < BL.
- R5: Length codes are 3'b000=1, 3'b001=2, 3'b010=4 and 3'b011=8 beats. A wrapped burst shows exactly that many beats, `last_o` is high on the final one only, and `valid_o` is low on the cycle after it unless a new start arrived.
- R6: Code 3'b111 with `interleave_i`=0 is a full-row burst. The column rises by one each cycle over all 8 bits, wrapping from 255 to 0, and `last_o` stays 0.
- R7: `stop_i` high at an edge during a burst makes `valid_o` 0 after that edge. `stop_i` while idle has no effect. A start in the same cycle as a stop wins.
- R8: Codes 3'b100, 3'b101 and 3'b110, and code 3'b111 with `interleave_i`=1, give a single beat with `last_o`=1. They also set `err_o`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new burst this cycle |
| start_col_i | input | 8 | First column of the burst |
| len_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 0 counting order, 1 XOR order |
| stop_i | input | 1 | End the running burst |
| col_o | output | 8 | Column of the current beat |
| valid_o | output | 1 | A beat is presented |
| last_o | output | 1 | Current beat is the final one |
| err_o | output | 1 | Sticky flag for an unusable length code |

## Verification
The assertions assume that `start_i` and `stop_i` are known 0 or 1 on every clock after reset. They also assume that the start column, length code and ordering bit are stable at the edge where a start is taken. Beyond that edge these three inputs are not used. The directed stimulus changes inputs only on falling edges and releases the start strobe one cycle after raising it. Each illegal code appears only as a single deliberate pulse, so every property sees well-formed control.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef enum logic {
    ORD_COUNT = 1'b0,
    ORD_XOR   = 1'b1
  } order_e;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
  import bcg_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int CODE_W = 3,
  parameter int MAX_LG = 3
) (
  input  logic [CODE_W-1:0] code_i,
  input  order_e            order_i,
  output logic [COL_W-1:0]  mask_o,
  output logic              full_o,
  output logic              bad_o
);
  localparam logic [CODE_W-1:0] FULL_CODE = '1;

  // low 'lg' bits set: the wrap window of a burst of 2**lg beats
  function automatic logic [COL_W-1:0] wrap_mask(input logic [CODE_W-1:0] lg);
    logic [COL_W-1:0] m;
    for (int i = 0; i < COL_W; i++) m[i] = (i < int'(lg));
    return m;
  endfunction

  always_comb begin
    mask_o = '0;
    full_o = 1'b0;
    bad_o  = 1'b0;
    if (int'(code_i) <= MAX_LG) begin
      mask_o = wrap_mask(code_i);
    end else if (code_i == FULL_CODE && order_i == ORD_COUNT) begin
      full_o = 1'b1;
      mask_o = '1;
    end else begin
      bad_o = 1'b1;   // one beat, mask stays zero
    end
  end
endmodule

// File: rtl/bcg_beat_ctr.sv
module bcg_beat_ctr
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  order_e           order_i,
  output logic             active_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output order_e           order_o,
  output logic             final_o
);
  logic stop_ev;
  logic done_ev;

  assign final_o = active_o && !full_o && (beat_o == mask_o);
  assign stop_ev = active_o && !start_i && stop_i;
  assign done_ev = active_o && !start_i && final_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      beat_o   <= '0;
      base_o   <= '0;
      mask_o   <= '0;
      full_o   <= 1'b0;
      order_o  <= ORD_COUNT;
    end else if (start_i) begin
      active_o <= 1'b1;
      beat_o   <= '0;
      base_o   <= base_i;
      mask_o   <= mask_i;
      full_o   <= full_i;
      order_o  <= order_i;
    end else if (active_o) begin
      if (stop_ev || done_ev) active_o <= 1'b0;
      else                    beat_o   <= beat_o + 1'b1;
    end
  end

  assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (active_o && beat_o == '0));

  assert_beat_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !start_i && !stop_i && !final_o) |=>
      (active_o && beat_o == COL_W'($past(beat_o) + 1'b1)));

  assert_stop_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !active_o);
endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  order_e           order_i,
  output logic [COL_W-1:0] col_o
);
  // counting order: add inside the window, keep bits above it
  function automatic logic [COL_W-1:0] count_col(input logic [COL_W-1:0] b,
                                                 input logic [COL_W-1:0] k,
                                                 input logic [COL_W-1:0] m);
    logic [COL_W-1:0] sum;
    sum = b + k;
    return (b & ~m) | (sum & m);
  endfunction

  // XOR order: flip the window bits by the beat index
  function automatic logic [COL_W-1:0] xor_col(input logic [COL_W-1:0] b,
                                               input logic [COL_W-1:0] k,
                                               input logic [COL_W-1:0] m);
    return b ^ (k & m);
  endfunction

  always_comb begin
    if (order_i == ORD_XOR) col_o = xor_col(base_i, beat_i, mask_i);
    else                    col_o = count_col(base_i, beat_i, mask_i);
  end
endmodule

// File: rtl/bcg_burst_col.sv
module bcg_burst_col
  import bcg_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int CODE_W = 3,
  parameter int MAX_LG = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [CODE_W-1:0] len_code_i,
  input  logic              interleave_i,
  input  logic              stop_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              last_o,
  output logic              err_o
);
  order_e           req_order;
  logic [COL_W-1:0] req_mask;
  logic             req_full;
  logic             req_bad;
  logic             act;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] cur_base;
  logic [COL_W-1:0] cur_mask;
  logic             cur_full;
  order_e           cur_order;
  logic             fin;
  logic             bad_start;

  assign req_order = order_e'(interleave_i);
  assign bad_start = start_i && req_bad;

  bcg_len_decode #(.COL_W(COL_W), .CODE_W(CODE_W), .MAX_LG(MAX_LG)) u_dec (
    .code_i (len_code_i),
    .order_i(req_order),
    .mask_o (req_mask),
    .full_o (req_full),
    .bad_o  (req_bad)
  );

  bcg_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .stop_i  (stop_i),
    .base_i  (start_col_i),
    .mask_i  (req_mask),
    .full_i  (req_full),
    .order_i (req_order),
    .active_o(act),
    .beat_o  (beat),
    .base_o  (cur_base),
    .mask_o  (cur_mask),
    .full_o  (cur_full),
    .order_o (cur_order),
    .final_o (fin)
  );

  bcg_addr_map #(.COL_W(COL_W)) u_map (
    .base_i (cur_base),
    .beat_i (beat),
    .mask_i (cur_mask),
    .order_i(cur_order),
    .col_o  (col_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         err_o <= 1'b0;
    else if (bad_start) err_o <= 1'b1;
  end

  assign valid_o = act;
  assign last_o  = fin;

  assert_upper_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (((col_o ^ cur_base) & ~cur_mask) == '0));

  assert_last_then_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !valid_o);

  assert_full_never_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && req_full) |=> (valid_o && !last_o));

  assert_bad_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_start |=> (last_o && err_o));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
endmodule

// File: tb/bcg_burst_col_test.sv
module bcg_burst_col_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       interleave_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [7:0] col_o;
  logic       valid_o;
  logic       last_o;
  logic       err_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bcg_burst_col uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .interleave_i(interleave_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected column, computed from the requirement text
  function automatic int exp_col(input int s, input int k, input int bl, input bit x);
    int lo;
    lo = s % bl;
    if (x) return s - lo + (lo ^ k);
    return s - lo + ((lo + k) % bl);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go(input int col, input int code, input bit x);
    start_i = 1'b1; start_col_i = 8'(col); len_code_i = 3'(code); interleave_i = x;
  endtask

  task automatic wrapped_burst(input string req, input int s, input int code, input bit x);
    int bl;
    bl = 1 << code;
    @(negedge clk);
    go(s, code, x);
    for (int k = 0; k < bl; k++) begin
      tick();
      start_i = 1'b0;
      chk({req, " col"}, col_o, exp_col(s, k, bl, x));
      chk({req, " valid"}, valid_o, 1);
      chk({req, " last (R5)"}, last_o, (k == bl - 1) ? 1 : 0);
    end
    tick();
    chk("R5 idle after final beat", valid_o, 0);
  endtask

  task automatic test_reset();
    chk("R1 valid", valid_o, 0);
    chk("R1 last", last_o, 0);
    chk("R1 err", err_o, 0);
  endtask

  task automatic test_idle_stop();
    @(negedge clk);
    stop_i = 1'b1;
    tick();
    stop_i = 1'b0;
    chk("R7 stop while idle", valid_o, 0);
    tick();
    chk("R7 stop while idle later", valid_o, 0);
  endtask

  task automatic test_full_row();
    @(negedge clk);
    go(8'hFC, 7, 1'b0);
    for (int k = 0; k < 6; k++) begin
      tick();
      start_i = 1'b0;
      chk("R6 full col", col_o, (8'hFC + k) & 8'hFF);
      chk("R6 full last", last_o, 0);
      chk("R6 full valid", valid_o, 1);
      if (k == 5) stop_i = 1'b1;
    end
    tick();
    stop_i = 1'b0;
    chk("R7 stop ends full row", valid_o, 0);
  endtask

  task automatic test_restart();
    @(negedge clk);
    go(8'h10, 3, 1'b0);
    for (int k = 0; k < 3; k++) begin
      tick();
      start_i = 1'b0;
      chk("R2 pre-restart col", col_o, 8'h10 + k);
    end
    go(8'h47, 1, 1'b1);
    tick();
    start_i = 1'b0;
    chk("R2 restart col", col_o, 8'h47);
    chk("R2 restart last", last_o, 0);
    tick();
    chk("R4 restart beat1", col_o, 8'h46);
    chk("R5 restart last", last_o, 1);
    tick();
    chk("R5 restart idle", valid_o, 0);
  endtask

  task automatic test_stop_and_start();
    @(negedge clk);
    go(8'h20, 2, 1'b0);
    tick();
    chk("R2 first beat", col_o, 8'h20);
    go(8'h80, 0, 1'b0);
    stop_i = 1'b1;
    tick();
    start_i = 1'b0;
    stop_i = 1'b0;
    chk("R7 start beats stop valid", valid_o, 1);
    chk("R7 start beats stop col", col_o, 8'h80);
    chk("R7 start beats stop last", last_o, 1);
    tick();
    chk("R7 idle after", valid_o, 0);
  endtask

  task automatic test_bad_codes();
    chk("R8 err clear before", err_o, 0);
    @(negedge clk);
    go(8'h33, 5, 1'b0);
    tick();
    start_i = 1'b0;
    chk("R8 reserved col", col_o, 8'h33);
    chk("R8 reserved last", last_o, 1);
    chk("R8 err set", err_o, 1);
    tick();
    chk("R8 reserved single beat", valid_o, 0);
    @(negedge clk);
    go(8'h70, 7, 1'b1);
    tick();
    start_i = 1'b0;
    chk("R8 full+xor last", last_o, 1);
    chk("R8 full+xor col", col_o, 8'h70);
    tick();
    chk("R8 full+xor single beat", valid_o, 0);
    wrapped_burst("R3 after error", 8'h5A, 1, 1'b0);
    chk("R8 err sticky", err_o, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_idle_stop();
    wrapped_burst("R3 seq BL4", 8'h3E, 2, 1'b0);
    wrapped_burst("R3 seq BL8", 8'h95, 3, 1'b0);
    wrapped_burst("R3 seq BL2", 8'h21, 1, 1'b0);
    wrapped_burst("R5 BL1", 8'hC7, 0, 1'b0);
    wrapped_burst("R4 xor BL8", 8'h95, 3, 1'b1);
    wrapped_burst("R4 xor BL4", 8'h0B, 2, 1'b1);
    test_full_row();
    test_restart();
    test_stop_and_start();
    test_bad_codes();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule